// File: doc/BRIEF.md
# Tagged Breakpoint Program Memory

This block is a byte-wide program memory in which every word carries one extra bit beside its eight data bits, and that bit serves as a breakpoint mark for its address. When the processor performs an opcode fetch from a marked byte and breakpoints are enabled, a pending-breakpoint flip-flop is set. The flip-flop also records the fetch address. The byte itself is returned unchanged, so the original instruction runs where it is stored. Any number of addresses can be marked, and no address comparators are involved.

A small control port selects between the data view and the tag view of the memory window, like a bank switch. In the tag view, reads return the mark of the addressed word in bit 0 and writes change only the mark. In the data view, writes change only the byte and keep the mark. A global enable masks breakpoint triggering but leaves the stored marks as they are. A write to the status register clears the pending flag.

The pending flag is kept by a two-state machine. `TRAP_IDLE` moves to `TRAP_PEND` on a qualifying fetch (transition *hit*). `TRAP_PEND` holds through later fetches (transition *hold*). It returns to `TRAP_IDLE` on a status clear (transition *clear*). A clear that arrives in the same cycle as a new qualifying fetch stays in `TRAP_PEND` and loads the new address (transition *reload*).

Top module: `bptag_mem`

## Requirements
- R1: Reset clears every data byte and every mark, the read data register, the pending flag, the recorded address, the tag-view select and the enable.
- R2: In the data view, a cycle with `cpu_rd` high makes `cpu_rdata` show the stored byte after that clock edge. Without `cpu_rd`, `cpu_rdata` holds its value.
- R3: In the data view, a write replaces the addressed byte and leaves its mark unchanged.
- R4: In the tag view, a read returns the mark in bit 0 with bits 7..1 zero. A write sets the mark to `cpu_wdata[0]` and leaves the data byte unchanged.
- R5: A read with `cpu_fetch` high, on a marked address, with the enable set, raises `bp_irq` after that edge and loads `bp_addr` with the fetch address. The fetch still returns the unmodified byte.
- R6: A read without `cpu_fetch` on a marked address never raises `bp_irq`.
- R7: While the enable is clear, no fetch raises `bp_irq`, and the stored marks are kept.
- R8: Once raised, `bp_irq` stays high and `bp_addr` keeps the first hit address through later qualifying fetches until a clear.
- R9: A status write (`reg_sel`=1) with `reg_wdata[0]`=1 drops `bp_irq` after the edge. If a qualifying fetch occurs in the same cycle, `bp_irq` stays high and `bp_addr` takes the new address.
- R10: A control write (`reg_sel`=0) loads the tag-view select from `reg_wdata[0]` and the enable from `reg_wdata[1]`. No other access changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | Memory window address |
| cpu_rd | input | 1 | Read strobe |
| cpu_fetch | input | 1 | Marks the read as an opcode fetch |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data (bit 0 only in tag view) |
| cpu_rdata | output | 8 | Registered read data |
| reg_wr | input | 1 | Control/status register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 2 | Register write data |
| bp_irq | output | 1 | Pending breakpoint flag |
| bp_addr | output | 8 | Address of the fetch that set the flag |

## Verification
The trigger is tried with four kinds of access to a marked byte: a plain operand read, an opcode fetch with the enable set, an opcode fetch with the enable clear, and a second fetch while a breakpoint is already pending. Together these separate a design that tests the mark on the fetch strobe from one that tests it on every read or ignores the mask. Marks and bytes are written through each view and then read back through the other, which shows that neither kind of write disturbs the other half of the word. A clear that coincides with a new hit, and a reset after marks have been placed, cover the reload transition and the clearing of the whole array.

// File: rtl/bptag_pkg.sv
package bptag_pkg;

    typedef enum logic [0:0] {
        TRAP_IDLE = 1'b0,
        TRAP_PEND = 1'b1
    } trap_state_t;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_STAT = 1'b1;

    localparam int unsigned CTRL_VIEW_BIT = 0;
    localparam int unsigned CTRL_EN_BIT   = 1;
    localparam int unsigned STAT_CLR_BIT  = 0;

endpackage

// File: rtl/bptag_store.sv
module bptag_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          tag_view,
    output logic [DW-1:0] rdata,
    output logic          tag_hit
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned WW    = DW + 1;
    localparam int unsigned TAG   = DW;

    logic [WW-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                word_q[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (wr) begin
                if (tag_view) begin
                    word_q[addr][TAG] <= wdata[0];
                end else begin
                    word_q[addr][DW-1:0] <= wdata;
                end
            end
            if (rd) begin
                if (tag_view) begin
                    rdata <= {{(DW-1){1'b0}}, word_q[addr][TAG]};
                end else begin
                    rdata <= word_q[addr][DW-1:0];
                end
            end
        end
    end

    assign tag_hit = word_q[addr][TAG];

    // R4: a tag-view write leaves the data byte alone
    p_tag_write_keeps_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tag_view) |=> (word_q[$past(addr)][DW-1:0] == $past(word_q[addr][DW-1:0])));

    // R3: a data-view write leaves the mark alone
    p_data_write_keeps_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !tag_view) |=> (word_q[$past(addr)][TAG] == $past(word_q[addr][TAG])));

    // R2: read register holds without a read strobe
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/bptag_ctrl.sv
module bptag_ctrl
    import bptag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [1:0] reg_wdata,
    output logic       tag_view,
    output logic       bp_enable,
    output logic       clr_req
);
    logic ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_sel == REG_CTRL);
    assign clr_req = reg_wr && (reg_sel == REG_STAT) && reg_wdata[STAT_CLR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_view  <= 1'b0;
            bp_enable <= 1'b0;
        end else if (ctrl_wr) begin
            tag_view  <= reg_wdata[CTRL_VIEW_BIT];
            bp_enable <= reg_wdata[CTRL_EN_BIT];
        end
    end

    // R10: only a control write moves the view select or the enable
    p_ctrl_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_sel == REG_CTRL)) |=> ($stable(tag_view) && $stable(bp_enable)));

endmodule

// File: rtl/bptag_trap.sv
module bptag_trap
    import bptag_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          fetch,
    input  logic          tag_hit,
    input  logic          bp_enable,
    input  logic          clr_req,
    output logic          bp_irq,
    output logic [AW-1:0] bp_addr
);
    trap_state_t state_q, state_d;
    logic        hit;
    logic        load_addr;

    assign hit = rd && fetch && tag_hit && bp_enable;

    always_comb begin
        state_d   = state_q;
        load_addr = 1'b0;
        unique case (state_q)
            TRAP_IDLE: begin
                if (hit) begin
                    state_d   = TRAP_PEND;
                    load_addr = 1'b1;
                end
            end
            TRAP_PEND: begin
                if (clr_req && hit) begin
                    state_d   = TRAP_PEND;
                    load_addr = 1'b1;
                end else if (clr_req) begin
                    state_d = TRAP_IDLE;
                end
            end
            default: state_d = TRAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_addr <= '0;
        end else if (load_addr) begin
            bp_addr <= addr;
        end
    end

    assign bp_irq = (state_q == TRAP_PEND);

    // R5: qualifying fetch from idle raises the flag and records the address
    p_hit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bp_irq && rd && fetch && tag_hit && bp_enable) |=> (bp_irq && bp_addr == $past(addr)));

    // R6: reads that are not fetches never raise the flag
    p_operand_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bp_irq && !fetch) |=> !bp_irq);

    // R7: masked breakpoints never raise the flag
    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bp_irq && !bp_enable) |=> !bp_irq);

    // R8: pending flag and address hold until cleared
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_irq && !clr_req) |=> (bp_irq && $stable(bp_addr)));

    // R9: clear without a new hit drops the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_irq && clr_req && !(rd && fetch && tag_hit && bp_enable)) |=> !bp_irq);

    // R9: clear coinciding with a hit reloads the address
    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && rd && fetch && tag_hit && bp_enable) |=> (bp_irq && bp_addr == $past(addr)));

endmodule

// File: rtl/bptag_mem.sv
module bptag_mem #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_fetch,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [1:0]        reg_wdata,
    output logic              bp_irq,
    output logic [ADDR_W-1:0] bp_addr
);
    logic tag_view;
    logic bp_enable;
    logic clr_req;
    logic tag_hit;

    bptag_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .tag_view  (tag_view),
        .bp_enable (bp_enable),
        .clr_req   (clr_req)
    );

    bptag_store #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .wr       (cpu_wr),
        .wdata    (cpu_wdata),
        .tag_view (tag_view),
        .rdata    (cpu_rdata),
        .tag_hit  (tag_hit)
    );

    bptag_trap #(
        .AW (ADDR_W)
    ) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (cpu_addr),
        .rd        (cpu_rd),
        .fetch     (cpu_fetch),
        .tag_hit   (tag_hit),
        .bp_enable (bp_enable),
        .clr_req   (clr_req),
        .bp_irq    (bp_irq),
        .bp_addr   (bp_addr)
    );

endmodule

// File: tb/bptag_mem_bench.sv
module bptag_mem_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_WR = 3'd0;
    localparam logic [2:0] OP_RD = 3'd1;
    localparam logic [2:0] OP_FE = 3'd2;
    localparam logic [2:0] OP_CT = 3'd3;
    localparam logic [2:0] OP_CL = 3'd4;
    localparam logic [2:0] OP_CK = 3'd5;

    function automatic logic [31:0] vec(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] d, input logic [7:0] e,
                                        input logic i, input logic [3:0] r);
        return {op, a, d, e, i, r};
    endfunction

    localparam int NV = 27;
    localparam logic [31:0] VECS [NV] = '{
        vec(OP_WR, 8'h10, 8'hA5, 8'h00, 1'b0, 4'd2),   // R2 load byte
        vec(OP_RD, 8'h10, 8'h00, 8'hA5, 1'b0, 4'd2),   // R2 read back
        vec(OP_CT, 8'h00, 8'h01, 8'h00, 1'b0, 4'd10),  // R10 tag view on
        vec(OP_WR, 8'h10, 8'h01, 8'h00, 1'b0, 4'd4),   // R4 set mark
        vec(OP_RD, 8'h10, 8'h00, 8'h01, 1'b0, 4'd4),   // R4 mark reads 1
        vec(OP_RD, 8'h11, 8'h00, 8'h00, 1'b0, 4'd4),   // R4 neighbour unmarked
        vec(OP_CT, 8'h00, 8'h00, 8'h00, 1'b0, 4'd10),  // R10 data view
        vec(OP_RD, 8'h10, 8'h00, 8'hA5, 1'b0, 4'd4),   // R4 byte untouched
        vec(OP_WR, 8'h10, 8'h3C, 8'h00, 1'b0, 4'd3),   // R3 rewrite byte
        vec(OP_RD, 8'h10, 8'h00, 8'h3C, 1'b0, 4'd3),   // R3 new byte
        vec(OP_CT, 8'h00, 8'h01, 8'h00, 1'b0, 4'd10),  // R10 tag view
        vec(OP_RD, 8'h10, 8'h00, 8'h01, 1'b0, 4'd3),   // R3 mark kept
        vec(OP_CT, 8'h00, 8'h02, 8'h00, 1'b0, 4'd10),  // R10 enable, data view
        vec(OP_RD, 8'h10, 8'h00, 8'h3C, 1'b0, 4'd6),   // R6 operand read no trigger
        vec(OP_FE, 8'h10, 8'h00, 8'h3C, 1'b1, 4'd5),   // R5 fetch triggers, byte intact
        vec(OP_CK, 8'h00, 8'h00, 8'h10, 1'b1, 4'd5),   // R5 address recorded
        vec(OP_WR, 8'h20, 8'h77, 8'h00, 1'b1, 4'd8),   // R8 second byte
        vec(OP_CT, 8'h00, 8'h03, 8'h00, 1'b1, 4'd10),  // R10 tag view, enabled
        vec(OP_WR, 8'h20, 8'h01, 8'h00, 1'b1, 4'd8),   // R8 mark second byte
        vec(OP_CT, 8'h00, 8'h02, 8'h00, 1'b1, 4'd10),  // R10 data view
        vec(OP_FE, 8'h20, 8'h00, 8'h77, 1'b1, 4'd8),   // R8 second hit while pending
        vec(OP_CK, 8'h00, 8'h00, 8'h10, 1'b1, 4'd8),   // R8 first address kept
        vec(OP_CL, 8'h00, 8'h01, 8'h00, 1'b0, 4'd9),   // R9 clear
        vec(OP_CK, 8'h00, 8'h00, 8'h10, 1'b0, 4'd9),   // R9 flag dropped
        vec(OP_CT, 8'h00, 8'h00, 8'h00, 1'b0, 4'd7),   // R7 disable
        vec(OP_FE, 8'h10, 8'h00, 8'h3C, 1'b0, 4'd7),   // R7 masked fetch
        vec(OP_CT, 8'h00, 8'h01, 8'h00, 1'b0, 4'd7)    // R7 tag view for readback
    };

    logic       clk;
    logic       rst_n;
    logic [7:0] cpu_addr;
    logic       cpu_rd;
    logic       cpu_fetch;
    logic       cpu_wr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       reg_wr;
    logic       reg_sel;
    logic [1:0] reg_wdata;
    logic       bp_irq;
    logic [7:0] bp_addr;

    int n_checks;
    int n_fails;

    bptag_mem u_bptag_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_fetch (cpu_fetch),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .bp_irq    (bp_irq),
        .bp_addr   (bp_addr)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic check(input int req, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cpu_rd    = 1'b0;
        cpu_fetch = 1'b0;
        cpu_wr    = 1'b0;
        reg_wr    = 1'b0;
    endtask

    // Drive one operation on the falling edge, let one rising edge pass,
    // then release strobes; outputs are sampled after that.
    task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        reg_wdata = d[1:0];
        unique case (op)
            OP_WR: cpu_wr = 1'b1;
            OP_RD: cpu_rd = 1'b1;
            OP_FE: begin cpu_rd = 1'b1; cpu_fetch = 1'b1; end
            OP_CT: begin reg_wr = 1'b1; reg_sel = 1'b0; end
            OP_CL: begin reg_wr = 1'b1; reg_sel = 1'b1; end
            default: ;
        endcase
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    initial begin
        n_checks  = 0;
        n_fails   = 0;
        rst_n     = 1'b0;
        cpu_addr  = '0;
        cpu_wdata = '0;
        reg_sel   = 1'b0;
        reg_wdata = '0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(1, "rdata after reset", cpu_rdata, 8'h00);
        check(1, "irq after reset", {7'b0, bp_irq}, 8'h00);
        check(1, "bp_addr after reset", bp_addr, 8'h00);

        for (int k = 0; k < NV; k++) begin
            logic [2:0] op;
            logic [7:0] a, d, e;
            logic       ei;
            logic [3:0] rq;
            {op, a, d, e, ei, rq} = VECS[k];
            apply(op, a, d);
            if (op == OP_RD || op == OP_FE) begin
                check(int'(rq), "read data", cpu_rdata, e);
                check(int'(rq), "irq", {7'b0, bp_irq}, {7'b0, ei});
            end else if (op == OP_CK) begin
                check(int'(rq), "bp_addr", bp_addr, e);
                check(int'(rq), "irq", {7'b0, bp_irq}, {7'b0, ei});
            end
        end

        // R7 marks survive while masked (tag view active from table)
        apply(OP_RD, 8'h10, 8'h00);
        check(7, "mark kept while masked", cpu_rdata, 8'h01);

        // R9 clear colliding with a new hit reloads the address
        apply(OP_CT, 8'h00, 8'h02);
        apply(OP_FE, 8'h10, 8'h00);
        check(9, "first hit irq", {7'b0, bp_irq}, 8'h01);
        @(negedge clk);
        cpu_addr  = 8'h20;
        cpu_rd    = 1'b1;
        cpu_fetch = 1'b1;
        reg_wr    = 1'b1;
        reg_sel   = 1'b1;
        reg_wdata = 2'b01;
        @(posedge clk);
        #1;
        idle_inputs();
        check(9, "irq after clear+hit", {7'b0, bp_irq}, 8'h01);
        check(9, "bp_addr after clear+hit", bp_addr, 8'h20);
        apply(OP_CL, 8'h00, 8'h01);
        check(9, "irq after clear", {7'b0, bp_irq}, 8'h00);

        // R1 reset in mid-run wipes marks, enable and bytes
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1, "irq after second reset", {7'b0, bp_irq}, 8'h00);
        check(1, "bp_addr after second reset", bp_addr, 8'h00);
        apply(OP_FE, 8'h10, 8'h00);
        check(1, "enable cleared by reset", {7'b0, bp_irq}, 8'h00);
        check(1, "byte cleared by reset", cpu_rdata, 8'h00);
        apply(OP_CT, 8'h00, 8'h01);
        apply(OP_RD, 8'h10, 8'h00);
        check(1, "mark cleared by reset", cpu_rdata, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule